// File: doc/BRIEF.md
# Write-Back Direct-Mapped Cache with One-Line Victim Store

This block is a data cache placed between a processor port and a line-oriented memory. Every address has a single home slot in a direct-mapped array. Each slot holds a line of neighbouring words (four by default). Stores stay inside the cache. A line goes out to memory only when it is pushed out, and only if it has been modified. A write that misses first brings the line in from memory and then applies the store to it.

Next to the array sits a store that holds exactly one line: the one most recently displaced from the array. A miss in the array that finds its line in this store exchanges the two lines without touching memory. This gives two lines that collide on the same index a second place to live. When a fill displaces a valid array line into the store and the store holds a modified line, that line is burst-written to memory before the fill starts.

The processor issues one word per request with a valid/ready handshake. While the cache is busy, `stall_o` is high and `req_ready_o` is low. The memory side moves one word per beat. A beat completes in any cycle where `mem_valid_o` and `mem_ready_i` are both high. Each burst covers one whole line, in word order.

Top module: `dmc_cache`

## Requirements
- R1: After reset no array line and no stored victim is valid, `req_ready_o` is 1 and `stall_o`, `mem_valid_o` and `rsp_valid_o` are 0, so the first access to any address misses.
- R2: An address splits into byte offset bits [1:0], word-in-line bits [3:2], index bits [7:4] (16 lines) and tag bits [31:8]; two addresses with the same index and different tags compete for one slot.
- R3: A read that hits the array raises `rsp_valid_o` with the word exactly one cycle after the request is accepted, and a write that hits leaves `req_ready_o` high in the next cycle; neither makes a memory beat.
- R4: A miss found in neither place reads the whole line in four beats whose addresses run from the line base upward by one word; `mem_rdata_i` is taken in the beat's cycle. A write miss also fetches before it stores.
- R5: Stores change only the cache; memory receives a line's data only when that line is written back, and then it receives the latest stored values.
- R6: A miss that finds its line in the victim store swaps the two lines with no memory beat, and the result appears three cycles after acceptance (two cycles more than a hit).
- R7: When a fill displaces a valid array line and the victim store holds a modified line, four write beats of that line, in word order from its base, come before the first read beat; a clean victim is never written.
- R8: A miss into an empty slot leaves the victim store unchanged and writes nothing to memory.
- R9: `stall_o` is high and `req_ready_o` low in every cycle that `mem_valid_o` is high, and a beat that is not accepted holds its address on the next cycle.
- R10: Every read returns the value of the most recent store to that address, or the memory content if there was none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor request present |
| req_ready_o | output | 1 | Cache can accept a request this cycle |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte address of the word |
| req_wdata_i | input | 32 | Store data |
| rsp_valid_o | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata_o | output | 32 | Load data |
| stall_o | output | 1 | Cache busy with a miss, swap or burst |
| mem_valid_o | output | 1 | Memory beat requested |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | 32 | Byte address of the beat's word |
| mem_wdata_o | output | 32 | Write beat data |
| mem_ready_i | input | 1 | Memory completes the beat this cycle |
| mem_rdata_i | input | 32 | Read beat data, valid while ready is high |

## Verification
The bench builds the cache with its default parameters: 16 lines of four 32-bit words. It restricts random addresses to two tag bits and the lowest four indices. That keeps index collisions frequent, so swaps, clean displacements and dirty write-backs all occur many times, and it lets a 256-word memory model cover every address used. Memory readiness is random, so beats stall mid-burst. A hand-built sequence before the random phase reaches the empty-slot miss with a modified victim and the write-back of a line that has travelled through the victim store twice.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SWAP,
    S_WB,
    S_FILL,
    S_INSTALL,
    S_RETRY
  } state_e;
endpackage

// File: rtl/dmc_array.sv
module dmc_array #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 24,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              idx_i,
  output logic                          rd_valid_o,
  output logic                          rd_dirty_o,
  output logic [TAG_W-1:0]              rd_tag_o,
  output logic [WORDS-1:0][DATA_W-1:0]  rd_line_o,
  input  logic                          line_we_i,
  input  logic [TAG_W-1:0]              line_tag_i,
  input  logic                          line_dirty_i,
  input  logic [WORDS-1:0][DATA_W-1:0]  line_data_i,
  input  logic                          word_we_i,
  input  logic [OFF_W-1:0]              word_sel_i,
  input  logic [DATA_W-1:0]             word_data_i
);
  logic [LINES-1:0]             valid_q, dirty_q;
  logic [TAG_W-1:0]             tag_q  [LINES];
  logic [WORDS-1:0][DATA_W-1:0] data_q [LINES];

  assign rd_valid_o = valid_q[idx_i];
  assign rd_dirty_o = dirty_q[idx_i];
  assign rd_tag_o   = tag_q[idx_i];
  assign rd_line_o  = data_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (line_we_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= line_dirty_i;
    end else if (word_we_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (line_we_i) begin
      tag_q[idx_i]  <= line_tag_i;
      data_q[idx_i] <= line_data_i;
    end else if (word_we_i) begin
      data_q[idx_i][word_sel_i] <= word_data_i;
    end
  end

  assert_one_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({line_we_i, word_we_i}));
  // stores only land in a present line (fetch before store)
  assert_store_present_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_we_i |-> valid_q[idx_i]);
endmodule

// File: rtl/dmc_victim.sv
module dmc_victim #(
  parameter int LA_W   = 28,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic                          load_valid_i,
  input  logic                          load_dirty_i,
  input  logic [LA_W-1:0]               load_la_i,
  input  logic [WORDS-1:0][DATA_W-1:0]  load_line_i,
  output logic                          valid_o,
  output logic                          dirty_o,
  output logic [LA_W-1:0]               la_o,
  output logic [WORDS-1:0][DATA_W-1:0]  line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dirty_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= load_valid_i;
      dirty_o <= load_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      la_o   <= load_la_i;
      line_o <= load_line_i;
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(valid_o) && $stable(dirty_o) && $stable(la_o) && $stable(line_o));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              stall_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import dmc_pkg::*;

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int LA_W   = TAG_W + IDX_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  typedef logic [WORDS-1:0][DATA_W-1:0] line_t;

  state_e            state_q;
  logic              q_we;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [OFF_W-1:0]  beat_q;
  line_t             fill_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic              idle;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;
  logic [DATA_W-1:0] cur_wdata;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [OFF_W-1:0]  cur_woff;
  logic [LA_W-1:0]   cur_la;
  logic              unused_byte;

  logic              arr_valid, arr_dirty;
  logic [TAG_W-1:0]  arr_tag;
  line_t             arr_line;
  logic              v_valid, v_dirty;
  logic [LA_W-1:0]   v_la;
  line_t             v_line;

  logic hit, vhit, do_op, arr_line_we, v_load, last_beat;

  assign idle      = (state_q == S_IDLE);
  assign cur_addr  = idle ? req_addr_i  : q_addr;
  assign cur_we    = idle ? req_we_i    : q_we;
  assign cur_wdata = idle ? req_wdata_i : q_wdata;
  assign cur_idx   = cur_addr[BYTE_W+OFF_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign cur_la    = cur_addr[ADDR_W-1 -: LA_W];
  assign cur_woff  = cur_addr[BYTE_W +: OFF_W];
  assign unused_byte = ^cur_addr[BYTE_W-1:0];

  assign hit       = arr_valid && (arr_tag == cur_tag);
  assign vhit      = v_valid && (v_la == cur_la);
  assign do_op     = (idle && req_valid_i && hit) || (state_q == S_RETRY);
  assign arr_line_we = (state_q == S_SWAP) || (state_q == S_INSTALL);
  assign v_load    = (state_q == S_SWAP) || ((state_q == S_INSTALL) && arr_valid);
  assign last_beat = (beat_q == LAST_BEAT);

  dmc_array #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_i        (cur_idx),
    .rd_valid_o   (arr_valid),
    .rd_dirty_o   (arr_dirty),
    .rd_tag_o     (arr_tag),
    .rd_line_o    (arr_line),
    .line_we_i    (arr_line_we),
    .line_tag_i   ((state_q == S_SWAP) ? v_la[LA_W-1 -: TAG_W] : cur_tag),
    .line_dirty_i ((state_q == S_SWAP) ? v_dirty : 1'b0),
    .line_data_i  ((state_q == S_SWAP) ? v_line : fill_q),
    .word_we_i    (do_op && cur_we),
    .word_sel_i   (cur_woff),
    .word_data_i  (cur_wdata)
  );

  dmc_victim #(.LA_W(LA_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (v_load),
    .load_valid_i (arr_valid),
    .load_dirty_i (arr_dirty),
    .load_la_i    ({arr_tag, cur_idx}),
    .load_line_i  (arr_line),
    .valid_o      (v_valid),
    .dirty_o      (v_dirty),
    .la_o         (v_la),
    .line_o       (v_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      q_we        <= 1'b0;
      q_addr      <= '0;
      q_wdata     <= '0;
      beat_q      <= '0;
      fill_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (do_op && !cur_we) begin
        rsp_valid_q <= 1'b1;
        rsp_rdata_q <= arr_line[cur_woff];
      end
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          q_we    <= req_we_i;
          q_addr  <= req_addr_i;
          q_wdata <= req_wdata_i;
          beat_q  <= '0;
          if (!hit) begin
            if (vhit)                               state_q <= S_SWAP;
            else if (arr_valid && v_valid && v_dirty) state_q <= S_WB;
            else                                    state_q <= S_FILL;
          end
        end
        S_SWAP:    state_q <= S_RETRY;
        S_WB: if (mem_ready_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= S_FILL;
        end
        S_FILL: if (mem_ready_i) begin
          fill_q[beat_q] <= mem_rdata_i;
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= S_INSTALL;
        end
        S_INSTALL: state_q <= S_RETRY;
        S_RETRY:   state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = idle;
  assign stall_o     = !idle;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign mem_valid_o = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we_o    = (state_q == S_WB);
  assign mem_addr_o  = (state_q == S_WB) ? {v_la, beat_q, {BYTE_W{1'b0}}}
                                         : {cur_la, beat_q, {BYTE_W{1'b0}}};
  assign mem_wdata_o = v_line[beat_q];

  assert_stall_burst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> stall_o && !req_ready_o);
  assert_beat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> mem_valid_o && $stable(mem_addr_o));
  assert_no_fetch_victim_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_we_o) |-> !(v_valid && v_la == mem_addr_o[ADDR_W-1 -: LA_W]));
  assert_wb_dirty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o) |-> (v_valid && v_dirty && arr_valid));
  assert_rsp_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_valid_o);
endmodule

// File: tb/tb_dmc_cache.sv
module tb_dmc_cache;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, stall_o;
  logic [31:0] rsp_rdata_o;
  logic        mem_valid_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b0;

  always #10 clk_i = ~clk_i;

  dmc_cache dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .stall_o(stall_o),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  int checks = 0, errors = 0;
  logic [31:0] bmem [256];
  logic [31:0] gold [256];

  // bench view of where each line lives
  logic        m_valid [16];
  logic        m_dirty [16];
  logic [23:0] m_tag   [16];
  logic        v_valid, v_dirty;
  logic [27:0] v_la;

  int          rd_beats, wr_beats;
  logic [27:0] exp_fill_la, exp_wb_la;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  assign mem_rdata_i = bmem[mem_addr_o[9:2]];

  always @(negedge clk_i) mem_ready_i <= ($urandom % 4) != 0;

  always @(posedge clk_i) if (rst_ni && mem_valid_o) begin
    chk("R9 stall during burst", {30'd0, stall_o, req_ready_o}, 32'd2);
    if (mem_ready_i) begin
      if (mem_we_o) begin
        chk("R7 write beat address", mem_addr_o, {exp_wb_la, 2'(wr_beats), 2'b00});
        chk("R5 written data", mem_wdata_o, gold[mem_addr_o[9:2]]);
        bmem[mem_addr_o[9:2]] = mem_wdata_o;
        wr_beats++;
      end else begin
        chk("R4 read beat address", mem_addr_o, {exp_fill_la, 2'(rd_beats), 2'b00});
        chk("R7 write before read", 32'(wr_beats == 0 || wr_beats == 4), 32'd1);
        rd_beats++;
      end
    end
  end

  task automatic do_op(input logic we, input logic [31:0] addr, input logic [31:0] wd);
    logic [3:0]  idx;
    logic [23:0] tg;
    int kind, exp_rd, exp_wr, lat;
    logic        t_valid, t_dirty;
    logic [27:0] t_la;
    idx = addr[7:4];
    tg  = addr[31:8];
    exp_fill_la = addr[31:4];
    exp_wb_la   = v_la;
    exp_rd = 0; exp_wr = 0;
    if (m_valid[idx] && m_tag[idx] == tg) kind = 0;
    else if (v_valid && v_la == addr[31:4]) begin
      kind = 1;
      t_valid = m_valid[idx]; t_dirty = m_dirty[idx]; t_la = {m_tag[idx], idx};
      m_valid[idx] = 1'b1; m_dirty[idx] = v_dirty; m_tag[idx] = v_la[27:4];
      v_valid = t_valid; v_dirty = t_dirty; v_la = t_la;
    end else begin
      kind = 2;
      exp_rd = 4;
      if (m_valid[idx]) begin
        if (v_valid && v_dirty) exp_wr = 4;
        v_valid = 1'b1; v_dirty = m_dirty[idx]; v_la = {m_tag[idx], idx};
      end
      m_valid[idx] = 1'b1; m_dirty[idx] = 1'b0; m_tag[idx] = tg;
    end
    if (we) m_dirty[idx] = 1'b1;
    rd_beats = 0; wr_beats = 0;

    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = addr; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1;
    if (!we) while (!rsp_valid_o && lat < 300) begin @(negedge clk_i); lat++; end
    else     while (!req_ready_o && lat < 300) begin @(negedge clk_i); lat++; end
    if (we) gold[addr[9:2]] = wd;
    else chk("R10 read data", rsp_rdata_o, gold[addr[9:2]]);
    while (!req_ready_o) @(negedge clk_i);
    chk("R4 read beats", 32'(rd_beats), 32'(exp_rd));
    chk("R7 write beats", 32'(wr_beats), 32'(exp_wr));
    if (kind == 0) chk("R3 hit latency", 32'(lat), 32'd1);
    if (kind == 1) chk("R6 swap latency", 32'(lat), 32'd3);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) begin bmem[i] = $urandom; gold[i] = bmem[i]; end
    for (int i = 0; i < 16; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; end
    v_valid = 1'b0; v_dirty = 1'b0; v_la = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset ready", {28'd0, req_ready_o, stall_o, mem_valid_o, rsp_valid_o}, 32'h8);

    do_op(1'b0, 32'h000, '0);          // R1 cold miss
    do_op(1'b0, 32'h004, '0);          // R3 read hit
    do_op(1'b1, 32'h008, 32'hA5A5_0001);
    do_op(1'b0, 32'h100, '0);          // R2 same index, new tag; dirty line to victim
    do_op(1'b0, 32'h008, '0);          // R6 swap back
    do_op(1'b0, 32'h200, '0);
    do_op(1'b0, 32'h300, '0);          // R7 dirty victim written out
    do_op(1'b1, 32'h204, 32'hA5A5_0002);
    do_op(1'b0, 32'h300, '0);          // victim now dirty
    do_op(1'b0, 32'h0F0, '0);          // R8 empty slot: no write-back
    do_op(1'b0, 32'h204, '0);          // R8 victim still there: swap
    do_op(1'b0, 32'h104, '0);
    do_op(1'b0, 32'h000, '0);          // R5 line with stores written out later

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = {22'd0, 2'($urandom), 2'b00, 2'($urandom), 2'($urandom), 2'b00};
      do_op(1'($urandom), a, $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule